// File: doc/BRIEF.md
# Block-granular security gate

This gate sits between a requester and a downstream memory. It divides the address space into equal blocks of a power-of-two size. Each block has one security bit in a lookup table, and that bit decides which security world may use the block. When the bit is 1, only non-secure transactions pass. When the bit is 0, only secure transactions pass. No block admits both worlds.

A transaction that matches its block's bit goes downstream one cycle later. A transaction that does not match never reaches the downstream port. It is sent to a blocked-access responder instead, which raises an error response. A blocked read returns zero data, and a blocked write is discarded. Every blocked access sets a sticky interrupt status bit. The interrupt line is asserted while that bit and an interrupt enable bit are both set.

Software programs the table through a small register port. It first writes a word index, then writes table words at that index. A full-width write also advances the index, so a run of writes fills the table in order.

The access path is a three-state machine:
- `ST_IDLE` means no response is being presented.
- `ST_FWD` means the previous cycle's transaction is presented downstream.
- `ST_BLK` means the previous cycle's transaction is presented to the blocked responder.

On every clock edge the machine chooses its next state from the current input alone, so any state can move to any state:
- A valid transaction that passes the check moves it to `ST_FWD`.
- A valid transaction that fails the check moves it to `ST_BLK`.
- No valid transaction moves it to `ST_IDLE`.

Top module: `sec_block_gate`

## Requirements
- R1: With a block size of B bytes, the address maps to block number k = addr >> log2(B). The bit that controls block k is bit (k mod 32) of table word (k / 32).
- R2: If the block's bit is 1, only a non-secure transaction (`txn_secure`=0) is forwarded. If the bit is 0, only a secure transaction is forwarded.
- R3: A transaction that fails the check never raises `ds_valid`. Instead it produces a one-cycle `blk_rsp_valid`, with `blk_rsp_err`=1 and `blk_rsp_rdata`=0, and its write data is dropped. `ds_valid` and `blk_rsp_valid` are never high together.
- R4: The register at `reg_sel`=0 is the table index. Writing it stores `reg_wdata` mod (number of table words), and reading it returns the index.
- R5: The register at `reg_sel`=1 is the table data port. A write with `reg_full`=1 stores the word at the current index and then increments the index, wrapping from the last word to 0. A read returns the word at the current index.
- R6: A table data write with `reg_full`=0 stores the word but leaves the index unchanged.
- R7: A table write takes effect for any transaction presented in the cycle after the write.
- R8: `irq` equals the interrupt status bit AND the interrupt enable bit. The enable bit is bit 0 of the register at `reg_sel`=2, which can be read and written.
- R9: Every blocked transaction sets the status bit, which reads as bit 0 at `reg_sel`=3. Writing 1 to bit 0 at `reg_sel`=4 clears it. If a block and a clear happen in the same cycle, the bit stays set.
- R10: After reset, every table bit is 0, the index is 0, the enable and status bits are 0, and no output is valid.
- R11: A transaction presented with `txn_valid` in one cycle appears on the downstream or blocked outputs after the next clock edge, for exactly one cycle. On the downstream side, address, write flag, write data and security attribute are carried unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 index, 1 table data, 2 enable, 3 status, 4 clear) |
| reg_wdata | input | 32 | Register write data |
| reg_full | input | 1 | Write is full 32-bit width |
| reg_rdata | output | 32 | Register read data for `reg_sel` (combinational) |
| txn_valid | input | 1 | Transaction present |
| txn_addr | input | ADDR_W | Transaction byte address |
| txn_secure | input | 1 | 1 = secure transaction |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_wdata | input | DATA_W | Write data |
| ds_valid | output | 1 | Forwarded transaction valid |
| ds_addr | output | ADDR_W | Forwarded address |
| ds_secure | output | 1 | Forwarded security attribute |
| ds_write | output | 1 | Forwarded write flag |
| ds_wdata | output | DATA_W | Forwarded write data |
| blk_rsp_valid | output | 1 | Blocked-access response valid |
| blk_rsp_write | output | 1 | Blocked access was a write |
| blk_rsp_err | output | 1 | Error flag for the blocked response |
| blk_rsp_rdata | output | DATA_W | Read data for a blocked read (zero) |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- the downstream and blocked outputs are never both valid;
- the index stays in range;
- the index advances, or holds, correctly after each kind of table write;
- a blocked access always leaves the status bit set;
- `irq` is never high without both the enable and status bits.

Other behaviour can only be shown by the bench's scenarios:
- the mapping from an address to its word and bit;
- a table write changing the very next decision;
- the index wrapping after a run of full writes;
- a clear losing to a block in the same cycle.

The bench compares those scenarios against a model table held in the bench.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_BLK  = 2'd2
    } gate_state_e;

    localparam logic [2:0] SEL_INDEX = 3'd0;
    localparam logic [2:0] SEL_TABLE = 3'd1;
    localparam logic [2:0] SEL_IEN   = 3'd2;
    localparam logic [2:0] SEL_ISTAT = 3'd3;
    localparam logic [2:0] SEL_ICLR  = 3'd4;

    localparam int LUT_BITS = 32;

endpackage

// File: rtl/sec_lut_regs.sv
module sec_lut_regs
    import sec_gate_pkg::*;
#(
    parameter int LUT_WORDS = 8,
    parameter int IDX_W     = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          sel,
    input  logic [31:0]         wdata,
    input  logic                full,
    input  logic [IDX_W-1:0]    lk_word,
    output logic [LUT_BITS-1:0] lk_bits,
    output logic [LUT_BITS-1:0] cur_word,
    output logic [IDX_W-1:0]    idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LUT_WORDS - 1);

    logic [LUT_BITS-1:0] lut_q [LUT_WORDS];
    logic [IDX_W-1:0]    idx_q;
    logic                wr_index;
    logic                wr_table;
    logic [IDX_W-1:0]    idx_next_wrap;

    assign wr_index      = wr_en && (sel == SEL_INDEX);
    assign wr_table      = wr_en && (sel == SEL_TABLE);
    assign idx_next_wrap = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (wr_index) begin
            idx_q <= IDX_W'(wdata % LUT_WORDS);
        end else if (wr_table && full) begin
            idx_q <= idx_next_wrap;
        end
    end

    generate
        for (genvar w = 0; w < LUT_WORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lut_q[w] <= '0;
                end else if (wr_table && (idx_q == IDX_W'(w))) begin
                    lut_q[w] <= wdata;
                end
            end
        end
    endgenerate

    assign lk_bits  = lut_q[lk_word];
    assign cur_word = lut_q[idx_q];
    assign idx_o    = idx_q;

    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx_q) < LUT_WORDS);

    p_full_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_table && full) |=>
            (idx_q == (($past(idx_q) == LAST_IDX) ? '0 : $past(idx_q) + 1'b1)));

    p_narrow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_table && !full) |=> $stable(idx_q));

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
    import sec_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  sel,
    input  logic        wbit,
    input  logic        blk_evt,
    output logic        en_o,
    output logic        stat_o,
    output logic        irq_o
);

    logic en_q;
    logic stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr_en && (sel == SEL_IEN)) begin
            en_q <= wbit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (blk_evt) begin
            stat_q <= 1'b1;
        end else if (wr_en && (sel == SEL_ICLR) && wbit) begin
            stat_q <= 1'b0;
        end
    end

    assign en_o   = en_q;
    assign stat_o = stat_q;
    assign irq_o  = en_q & stat_q;

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_o && stat_o));

    p_set_on_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_evt |=> stat_o);

endmodule

// File: rtl/sec_access_fsm.sv
module sec_access_fsm
    import sec_gate_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int BLK_BYTES = 256,
    parameter int IDX_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                txn_valid,
    input  logic [ADDR_W-1:0]   txn_addr,
    input  logic                txn_secure,
    input  logic                txn_write,
    input  logic [DATA_W-1:0]   txn_wdata,
    output logic [IDX_W-1:0]    lk_word,
    input  logic [LUT_BITS-1:0] lk_bits,
    output logic                blk_evt,
    output logic                ds_valid,
    output logic [ADDR_W-1:0]   ds_addr,
    output logic                ds_secure,
    output logic                ds_write,
    output logic [DATA_W-1:0]   ds_wdata,
    output logic                blk_rsp_valid,
    output logic                blk_rsp_write,
    output logic                blk_rsp_err,
    output logic [DATA_W-1:0]   blk_rsp_rdata
);

    localparam int BLK_SHIFT = $clog2(BLK_BYTES);
    localparam int BLKNUM_W  = ADDR_W - BLK_SHIFT;

    gate_state_e         state_q;
    gate_state_e         state_d;
    logic [BLKNUM_W-1:0] blk_num;
    logic [4:0]          bit_pos;
    logic                blk_bit;
    logic                pass;
    logic [ADDR_W-1:0]   addr_q;
    logic                sec_q;
    logic                wr_q;
    logic [DATA_W-1:0]   wdata_q;

    assign blk_num = BLKNUM_W'(txn_addr >> BLK_SHIFT);
    assign bit_pos = blk_num[4:0];
    assign lk_word = IDX_W'(blk_num >> 5);
    assign blk_bit = lk_bits[bit_pos];
    assign pass    = (blk_bit == ~txn_secure);
    assign blk_evt = txn_valid && !pass;

    always_comb begin
        if (!txn_valid) begin
            state_d = ST_IDLE;
        end else if (pass) begin
            state_d = ST_FWD;
        end else begin
            state_d = ST_BLK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            sec_q   <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (txn_valid) begin
            addr_q  <= txn_addr;
            sec_q   <= txn_secure;
            wr_q    <= txn_write;
            wdata_q <= pass ? txn_wdata : '0;
        end
    end

    always_comb begin
        ds_valid      = 1'b0;
        ds_addr       = '0;
        ds_secure     = 1'b0;
        ds_write      = 1'b0;
        ds_wdata      = '0;
        blk_rsp_valid = 1'b0;
        blk_rsp_write = 1'b0;
        blk_rsp_err   = 1'b0;
        blk_rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_FWD: begin
                ds_valid  = 1'b1;
                ds_addr   = addr_q;
                ds_secure = sec_q;
                ds_write  = wr_q;
                ds_wdata  = wdata_q;
            end
            ST_BLK: begin
                blk_rsp_valid = 1'b1;
                blk_rsp_write = wr_q;
                blk_rsp_err   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ds_valid && blk_rsp_valid));

    p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_valid || blk_rsp_valid) |-> $past(txn_valid));

    p_world_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && pass) |=> (ds_valid && (ds_secure != $past(blk_bit))));

    p_block_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_evt |=> (blk_rsp_valid && blk_rsp_err && !ds_valid));

endmodule

// File: rtl/sec_block_gate.sv
module sec_block_gate
    import sec_gate_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int BLK_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_full,
    output logic [31:0]       reg_rdata,
    input  logic              txn_valid,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              txn_secure,
    input  logic              txn_write,
    input  logic [DATA_W-1:0] txn_wdata,
    output logic              ds_valid,
    output logic [ADDR_W-1:0] ds_addr,
    output logic              ds_secure,
    output logic              ds_write,
    output logic [DATA_W-1:0] ds_wdata,
    output logic              blk_rsp_valid,
    output logic              blk_rsp_write,
    output logic              blk_rsp_err,
    output logic [DATA_W-1:0] blk_rsp_rdata,
    output logic              irq
);

    localparam int BLK_SHIFT = $clog2(BLK_BYTES);
    localparam int NUM_BLKS  = 1 << (ADDR_W - BLK_SHIFT);
    localparam int LUT_WORDS = (NUM_BLKS + LUT_BITS - 1) / LUT_BITS;
    localparam int IDX_W     = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1;

    logic [IDX_W-1:0]    lk_word;
    logic [LUT_BITS-1:0] lk_bits;
    logic [LUT_BITS-1:0] cur_word;
    logic [IDX_W-1:0]    idx;
    logic                blk_evt;
    logic                int_en;
    logic                int_stat;

    sec_lut_regs #(
        .LUT_WORDS (LUT_WORDS),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wen),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .full     (reg_full),
        .lk_word  (lk_word),
        .lk_bits  (lk_bits),
        .cur_word (cur_word),
        .idx_o    (idx)
    );

    sec_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wen),
        .sel     (reg_sel),
        .wbit    (reg_wdata[0]),
        .blk_evt (blk_evt),
        .en_o    (int_en),
        .stat_o  (int_stat),
        .irq_o   (irq)
    );

    sec_access_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BLK_BYTES (BLK_BYTES),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .txn_valid     (txn_valid),
        .txn_addr      (txn_addr),
        .txn_secure    (txn_secure),
        .txn_write     (txn_write),
        .txn_wdata     (txn_wdata),
        .lk_word       (lk_word),
        .lk_bits       (lk_bits),
        .blk_evt       (blk_evt),
        .ds_valid      (ds_valid),
        .ds_addr       (ds_addr),
        .ds_secure     (ds_secure),
        .ds_write      (ds_write),
        .ds_wdata      (ds_wdata),
        .blk_rsp_valid (blk_rsp_valid),
        .blk_rsp_write (blk_rsp_write),
        .blk_rsp_err   (blk_rsp_err),
        .blk_rsp_rdata (blk_rsp_rdata)
    );

    always_comb begin
        unique case (reg_sel)
            SEL_INDEX: reg_rdata = 32'(idx);
            SEL_TABLE: reg_rdata = cur_word;
            SEL_IEN:   reg_rdata = {31'd0, int_en};
            SEL_ISTAT: reg_rdata = {31'd0, int_stat};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/sec_block_gate_tb.sv
module sec_block_gate_tb;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int NW     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wen = 1'b0;
    logic [2:0]        reg_sel = 3'd0;
    logic [31:0]       reg_wdata = '0;
    logic              reg_full = 1'b0;
    logic [31:0]       reg_rdata;
    logic              txn_valid = 1'b0;
    logic [ADDR_W-1:0] txn_addr = '0;
    logic              txn_secure = 1'b0;
    logic              txn_write = 1'b0;
    logic [DATA_W-1:0] txn_wdata = '0;
    logic              ds_valid;
    logic [ADDR_W-1:0] ds_addr;
    logic              ds_secure;
    logic              ds_write;
    logic [DATA_W-1:0] ds_wdata;
    logic              blk_rsp_valid;
    logic              blk_rsp_write;
    logic              blk_rsp_err;
    logic [DATA_W-1:0] blk_rsp_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_lut [NW];
    int          m_idx;
    bit          m_en;
    bit          m_stat;

    always #4 clk = ~clk;

    sec_block_gate u_dut (
        .clk (clk), .rst_n (rst_n),
        .reg_wen (reg_wen), .reg_sel (reg_sel), .reg_wdata (reg_wdata),
        .reg_full (reg_full), .reg_rdata (reg_rdata),
        .txn_valid (txn_valid), .txn_addr (txn_addr), .txn_secure (txn_secure),
        .txn_write (txn_write), .txn_wdata (txn_wdata),
        .ds_valid (ds_valid), .ds_addr (ds_addr), .ds_secure (ds_secure),
        .ds_write (ds_write), .ds_wdata (ds_wdata),
        .blk_rsp_valid (blk_rsp_valid), .blk_rsp_write (blk_rsp_write),
        .blk_rsp_err (blk_rsp_err), .blk_rsp_rdata (blk_rsp_rdata),
        .irq (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_pass(input logic [ADDR_W-1:0] a, input bit s);
        int k = int'(a) >> 8;
        return m_lut[k >> 5][k & 31] == !s;
    endfunction

    task automatic model_write(input logic [2:0] sel, input logic [31:0] d,
                               input bit full);
        case (sel)
            3'd0: m_idx = int'(d % NW);
            3'd1: begin
                m_lut[m_idx] = d;
                if (full) m_idx = (m_idx + 1) % NW;
            end
            3'd2: m_en = d[0];
            3'd4: if (d[0]) m_stat = 1'b0;
            default: ;
        endcase
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] d,
                             input bit full);
        @(negedge clk);
        reg_wen = 1'b1; reg_sel = sel; reg_wdata = d; reg_full = full;
        @(negedge clk);
        reg_wen = 1'b0; reg_full = 1'b0;
        model_write(sel, d, full);
    endtask

    task automatic reg_check(input logic [2:0] sel, input logic [31:0] exp,
                             input string tag);
        reg_sel = sel;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input bit s, input bit w,
                          input logic [31:0] d, input string tag);
        bit p;
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = a; txn_secure = s; txn_write = w;
        txn_wdata = d;
        p = exp_pass(a, s);
        @(negedge clk);
        txn_valid = 1'b0;
        if (!p) m_stat = 1'b1;
        chk(ds_valid == p, {tag, " R2 ds_valid"}, 32'(ds_valid), 32'(p));
        chk(blk_rsp_valid == !p, {tag, " R3 blk_rsp_valid"},
            32'(blk_rsp_valid), 32'(!p));
        if (p) begin
            chk(ds_addr == a && ds_secure == s && ds_write == w && ds_wdata == d,
                {tag, " R11 forwarded fields"}, 32'(ds_addr), 32'(a));
        end else begin
            chk(blk_rsp_err && blk_rsp_rdata == 0 && blk_rsp_write == w,
                {tag, " R3 blocked response"}, blk_rsp_rdata, 32'd0);
        end
        chk(irq == (m_stat && m_en), {tag, " R8 irq"}, 32'(irq),
            32'(m_stat && m_en));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) m_lut[i] = '0;
        m_idx = 0; m_en = 0; m_stat = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        reg_check(3'd0, 32'd0, "R10 index");
        reg_check(3'd1, 32'd0, "R10 table word");
        reg_check(3'd2, 32'd0, "R10 enable");
        reg_check(3'd3, 32'd0, "R10 status");
        chk(!ds_valid && !blk_rsp_valid && !irq, "R10 outputs idle",
            32'({ds_valid, blk_rsp_valid, irq}), 32'd0);

        access(16'h0040, 1'b1, 1'b0, 32'h0, "R10 secure ok at reset");
        access(16'h0040, 1'b0, 1'b1, 32'h1234, "R10 nonsecure blocked at reset");
        reg_check(3'd3, 32'd1, "R9 status set by block");

        reg_write(3'd0, 32'd13, 1'b0);
        reg_check(3'd0, 32'd5, "R4 index modulo");

        reg_write(3'd0, 32'd7, 1'b0);
        reg_write(3'd1, 32'hA5A5_0001, 1'b1);
        reg_check(3'd0, 32'd0, "R5 index wraps to zero");

        reg_write(3'd0, 32'd2, 1'b0);
        reg_write(3'd1, 32'h0000_0020, 1'b0);
        reg_check(3'd0, 32'd2, "R6 narrow write keeps index");
        reg_check(3'd1, 32'h0000_0020, "R6 narrow write stores word");

        access(16'((2 * 32 + 5) * 256), 1'b0, 1'b0, 0, "R1 word2 bit5 nonsecure");
        access(16'((2 * 32 + 4) * 256 + 8'hFF), 1'b0, 1'b0, 0,
               "R1 word2 bit4 nonsecure");
        access(16'((2 * 32 + 5) * 256 + 8'h7C), 1'b1, 1'b1, 32'hDEAD,
               "R2 secure to nonsecure block");

        reg_write(3'd1, 32'h0000_0000, 1'b1);
        access(16'((2 * 32 + 5) * 256), 1'b1, 1'b0, 0, "R7 immediate effect");

        reg_write(3'd4, 32'd1, 1'b0);
        reg_check(3'd3, 32'd0, "R9 clear");
        reg_write(3'd2, 32'd1, 1'b0);
        reg_check(3'd2, 32'd1, "R8 enable readback");
        access(16'h0100, 1'b0, 1'b0, 0, "R8 irq on block");

        @(negedge clk);
        txn_valid = 1'b1; txn_addr = 16'h0200; txn_secure = 1'b0;
        txn_write = 1'b0;
        reg_wen = 1'b1; reg_sel = 3'd4; reg_wdata = 32'd1;
        @(negedge clk);
        txn_valid = 1'b0; reg_wen = 1'b0;
        m_stat = 1'b1;
        reg_check(3'd3, 32'd1, "R9 set beats clear");

        for (int n = 0; n < 400; n++) begin
            int op = int'($urandom_range(0, 9));
            if (op < 2) reg_write(3'd1, $urandom, bit'($urandom_range(0, 1)));
            else if (op == 2) reg_write(3'd0, $urandom, 1'b0);
            else if (op == 3) reg_write(3'd2, 32'($urandom_range(0, 1)), 1'b0);
            else if (op == 4) reg_write(3'd4, 32'($urandom_range(0, 1)), 1'b0);
            else access(16'($urandom), bit'($urandom_range(0, 1)),
                        bit'($urandom_range(0, 1)), $urandom, "R2 random");
        end

        for (int w = 0; w < NW; w++) begin
            reg_write(3'd0, 32'(w), 1'b0);
            reg_check(3'd1, m_lut[w], "R5 table readback");
        end
        reg_check(3'd3, 32'(m_stat), "R9 final status");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule